// File: doc/BRIEF.md
# Quota-Gated Weighted Round-Robin Arbiter

This block shares one resource among N clients and grants each a bounded, unequal fraction of the turns. Every client carries a small unsigned weight. A per-client counter tracks how many grants that client has taken in the current round. Once the counter reaches the weight, the client's request is hidden from arbitration. The requests that remain feed a round-robin core that gives the lowest priority to the client it served last. A client with weight 3 therefore receives up to three turns for every single turn of a client with weight 1.

The grant is combinational from the current request vector and the registered state, so a grant appears in the same cycle as the request. On each rising clock edge the counters and the round-robin pointer take account of that grant. The gating stage has two modes:

- `GATE_NORMAL`: only requesters with quota left compete.
- `GATE_REFRESH`: requests are present, but every one of them has spent its quota.

The gate moves from `GATE_NORMAL` to `GATE_REFRESH` as soon as no requesting client has quota left. It returns to `GATE_NORMAL` on the next edge. That edge clears all counters and charges the grant just issued as the first grant of the new round. The design therefore never stalls and never spends an idle cycle on a refresh.

Top module: `wrr_arbiter`

## Requirements
- R1: At most one bit of `gnt` is set in any cycle.
- R2: `gnt` bit i is set only when `req` bit i is set, where bit i of both vectors belongs to client i.
- R3: When `req` is all zero, `gnt` is zero. When any `req` bit is set, some `gnt` bit is set in the same cycle.
- R4: With equal weights and every client requesting, grants rotate by ascending index and wrap from N-1 to 0.
- R5: After client i is granted, the next grant goes to the lowest-numbered competing client above i. If there is none, it goes to the lowest-numbered competing client overall.
- R6: A client that has been granted as many times as its weight since the last counter clear is excluded while any other requesting client still has quota.
- R7: A weight value of 0 behaves exactly like a weight of 1.
- R8: When requests are present but none of the requesting clients has quota left, all counters clear and the grant is chosen among all requests in that same cycle. That grant counts as the first grant of the new round.
- R9: After reset every counter is zero and client 0 holds the highest priority, so an all-ones request yields grant `0001`. A reset in mid-run restores this state.
- R10: The `weights` port holds client i's unsigned weight in bits [i*WW +: WW]. With N=4, weights (client 0 to 3) of 3,1,1,1 and all clients requesting, the grants settle into repeating rounds in which client 0 receives 3 of every 6 grants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N | Request vector, bit i from client i |
| weights | input | N*WW | Packed per-client weights, client i at [i*WW +: WW] |
| gnt | output | N | One-hot (or zero) grant vector, combinational |

## Verification
The stimulus patterns are chosen so that each one separates a different mechanism:

- **Equal weights, all clients requesting:** shows pure rotation. The quota gate and the refresh path interleave with it without adding a cycle.
- **Skewed weights (3,1,1,1):** shows the quota mask at work, because client 0 keeps winning on its own only after the others are spent.
- **All-zero weights with a sparse request set:** shows that zero is promoted to one.
- **Sparse and changing request sets (a single client, two-client pairs, gaps in the index order):** show the wrap and skip behaviour of the pointer. They also show that a refresh fires on a lone repeated requester without a dead cycle.
- **Sweep of every request pattern from reset:** confirms lowest-index selection and the one-hot, requester-only grant.

// File: rtl/wrr_pkg.sv
package wrr_pkg;

    // Operating mode of the quota gate for the current cycle
    typedef enum logic {
        GATE_NORMAL  = 1'b0,  // only clients with quota left compete
        GATE_REFRESH = 1'b1   // every requesting client is spent: start a new round
    } gate_mode_e;

endpackage

// File: rtl/wrr_prio_pick.sv
module wrr_prio_pick #(
    parameter int N = 4
) (
    input  logic [N-1:0] bits_in,
    output logic [N-1:0] first_out
);

    // seen[i] is set when some bit below index i is already set
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_chain
            assign seen[i+1]    = seen[i] | bits_in[i];
            assign first_out[i] = bits_in[i] & ~seen[i];
        end
    endgenerate

endmodule

// File: rtl/wrr_quota_gate.sv
module wrr_quota_gate
    import wrr_pkg::*;
#(
    parameter int N  = 4,
    parameter int WW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N*WW-1:0] weights,
    input  logic [N-1:0]    gnt,
    output logic [N-1:0]    req_eff
);

    localparam logic [WW-1:0] ONE = {{(WW-1){1'b0}}, 1'b1};

    logic [N-1:0] spent;
    logic [N-1:0] eligible;
    logic [N-1:0] cnt_nz;
    gate_mode_e   mode;

    generate
        for (genvar i = 0; i < N; i++) begin : g_client
            logic [WW-1:0] raw_w;
            logic [WW-1:0] lim;
            logic [WW-1:0] cnt_q;

            assign raw_w    = weights[i*WW +: WW];
            // a zero weight is promoted to one
            assign lim      = (raw_w == '0) ? ONE : raw_w;
            assign spent[i] = (cnt_q >= lim);
            assign cnt_nz[i] = (cnt_q != '0);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (mode == GATE_REFRESH) begin
                    cnt_q <= gnt[i] ? ONE : '0;
                end else if (gnt[i]) begin
                    cnt_q <= cnt_q + ONE;
                end
            end

            // R6: a counter never runs past its client's quota
            assert_quota_bound_R6 : assert property (
                @(posedge clk) disable iff (!rst_n) cnt_q <= lim
            );
        end
    endgenerate

    assign eligible = req & ~spent;

    // mode decision
    always_comb begin
        mode = (|req && !(|eligible)) ? GATE_REFRESH : GATE_NORMAL;
    end

    // gated request output
    always_comb begin
        unique case (mode)
            GATE_NORMAL:  req_eff = eligible;
            GATE_REFRESH: req_eff = req;
            default:      req_eff = '0;
        endcase
    end

    // R8: after a refresh at most the newly granted client holds a count
    assert_refresh_clear_R8 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (mode == GATE_REFRESH) |=> ($countones(cnt_nz) <= 1)
    );

endmodule

// File: rtl/wrr_rr_core.sv
module wrr_rr_core #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_in,
    output logic [N-1:0] gnt
);

    localparam logic [N-1:0] LSB = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0] ptr_q;   // ones above the last served index
    logic [N-1:0] hi_req;
    logic [N-1:0] hi_gnt;
    logic [N-1:0] lo_gnt;
    logic [N-1:0] above;

    assign hi_req = req_in & ptr_q;

    wrr_prio_pick #(.N(N)) i_pick_masked (
        .bits_in   (hi_req),
        .first_out (hi_gnt)
    );

    wrr_prio_pick #(.N(N)) i_pick_plain (
        .bits_in   (req_in),
        .first_out (lo_gnt)
    );

    assign gnt   = (|hi_req) ? hi_gnt : lo_gnt;
    assign above = ~((gnt << 1) - LSB);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '1;
        end else if (|gnt) begin
            ptr_q <= above;
        end
    end

    // R5: the client just served is excluded from the high-priority half
    assert_served_lowest_R5 : assert property (
        @(posedge clk) disable iff (!rst_n)
        (|gnt) |=> ((ptr_q & $past(gnt)) == '0)
    );

endmodule

// File: rtl/wrr_arbiter.sv
module wrr_arbiter #(
    parameter int N  = 4,
    parameter int WW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic [N*WW-1:0] weights,
    output logic [N-1:0]    gnt
);

    logic [N-1:0] req_eff;

    wrr_quota_gate #(.N(N), .WW(WW)) i_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .weights (weights),
        .gnt     (gnt),
        .req_eff (req_eff)
    );

    wrr_rr_core #(.N(N)) i_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (req_eff),
        .gnt    (gnt)
    );

    assert_onehot_grant_R1 : assert property (
        @(posedge clk) disable iff (!rst_n) $onehot0(gnt)
    );

    assert_grant_to_requester_R2 : assert property (
        @(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0
    );

    assert_idle_no_grant_R3 : assert property (
        @(posedge clk) disable iff (!rst_n) (req == '0) |-> (gnt == '0)
    );

    assert_busy_some_grant_R3 : assert property (
        @(posedge clk) disable iff (!rst_n) (req != '0) |-> (gnt != '0)
    );

endmodule

// File: tb/test_wrr_arbiter.sv
`timescale 1ns/1ps
module test_wrr_arbiter;

    localparam int N  = 4;
    localparam int WW = 3;
    localparam int NV = 34;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req = '0;
    logic [N*WW-1:0] weights = '0;
    logic [N-1:0]    gnt;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;   // 250 MHz

    wrr_arbiter #(.N(N), .WW(WW)) i_wrr_arbiter (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .weights (weights),
        .gnt     (gnt)
    );

    // entry: {reset_first, tag, req, weights(w3,w2,w1,w0), expected gnt}
    // weights 12'h249 = all 1, 12'h24B = 3,1,1,1 (client 0 first), 12'h000 = all 0, 12'h492 = all 2
    localparam logic [24:0] VEC [NV] = '{
        // R9 then R4: equal weights rotate with refresh folded in
        {1'b1, 4'd9,  4'b1111, 12'h249, 4'b0001},
        {1'b0, 4'd4,  4'b1111, 12'h249, 4'b0010},
        {1'b0, 4'd4,  4'b1111, 12'h249, 4'b0100},
        {1'b0, 4'd4,  4'b1111, 12'h249, 4'b1000},
        {1'b0, 4'd4,  4'b1111, 12'h249, 4'b0001},
        // R6 / R10: client 0 weight 3
        {1'b1, 4'd10, 4'b1111, 12'h24B, 4'b0001},
        {1'b0, 4'd10, 4'b1111, 12'h24B, 4'b0010},
        {1'b0, 4'd10, 4'b1111, 12'h24B, 4'b0100},
        {1'b0, 4'd10, 4'b1111, 12'h24B, 4'b1000},
        {1'b0, 4'd6,  4'b1111, 12'h24B, 4'b0001},
        {1'b0, 4'd6,  4'b1111, 12'h24B, 4'b0001},
        {1'b0, 4'd8,  4'b1111, 12'h24B, 4'b0010},
        {1'b0, 4'd10, 4'b1111, 12'h24B, 4'b0100},
        {1'b0, 4'd10, 4'b1111, 12'h24B, 4'b1000},
        {1'b0, 4'd6,  4'b1111, 12'h24B, 4'b0001},
        {1'b0, 4'd6,  4'b1111, 12'h24B, 4'b0001},
        {1'b0, 4'd6,  4'b1111, 12'h24B, 4'b0001},
        {1'b0, 4'd8,  4'b1111, 12'h24B, 4'b0010},
        // R7: zero weights act as one
        {1'b1, 4'd7,  4'b0101, 12'h000, 4'b0001},
        {1'b0, 4'd7,  4'b0101, 12'h000, 4'b0100},
        {1'b0, 4'd7,  4'b0101, 12'h000, 4'b0001},
        {1'b0, 4'd7,  4'b0101, 12'h000, 4'b0100},
        // R3 / R8 / R5: idle, lone requester, pair
        {1'b1, 4'd3,  4'b0000, 12'h249, 4'b0000},
        {1'b0, 4'd5,  4'b1000, 12'h249, 4'b1000},
        {1'b0, 4'd8,  4'b1000, 12'h249, 4'b1000},
        {1'b0, 4'd3,  4'b0000, 12'h249, 4'b0000},
        {1'b0, 4'd5,  4'b0110, 12'h249, 4'b0010},
        {1'b0, 4'd6,  4'b0110, 12'h249, 4'b0100},
        // R5 / R8: gaps in the index order, weight 2
        {1'b1, 4'd5,  4'b1010, 12'h492, 4'b0010},
        {1'b0, 4'd5,  4'b1011, 12'h492, 4'b1000},
        {1'b0, 4'd5,  4'b1011, 12'h492, 4'b0001},
        {1'b0, 4'd5,  4'b0011, 12'h492, 4'b0010},
        {1'b0, 4'd6,  4'b0011, 12'h492, 4'b0001},
        {1'b0, 4'd8,  4'b0011, 12'h492, 4'b0010}
    };

    task automatic check(input int tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL R%0d: gnt got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic [N*WW-1:0] w);
        @(negedge clk);
        rst_n   = 1'b0;
        req     = '0;
        weights = w;
        @(negedge clk);
        rst_n   = 1'b1;
    endtask

    initial begin
        // vector walk
        for (int k = 0; k < NV; k++) begin
            logic [24:0] e;
            e = VEC[k];
            if (e[24]) do_reset(e[15:4]);
            else @(negedge clk);
            req     = e[19:16];
            weights = e[15:4];
            #1;
            check(int'(e[23:20]), gnt, e[3:0]);
        end

        // R1 / R2: every request pattern from reset picks the lowest index
        for (int p = 0; p < 16; p++) begin
            logic [N-1:0] pv;
            pv = p[N-1:0];
            do_reset(12'h249);
            req = pv;
            #1;
            check(2, gnt, pv & (~pv + 4'b0001));
            check(1, 4'($countones(gnt) <= 1), 4'd1);
        end

        // R9: reset in mid-run restores client 0 priority
        do_reset(12'h249);
        req = 4'b1111;
        #1; check(9, gnt, 4'b0001);
        @(negedge clk); #1; check(9, gnt, 4'b0010);
        do_reset(12'h249);
        req = 4'b1111;
        #1; check(9, gnt, 4'b0001);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL R3: watchdog got hang expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule